// File: doc/BRIEF.md
# MII Management Register Controller

This block lets a host read and write PHY registers over the two-wire management link, using clause-22 frames. The host sees two 16-bit registers behind a single write strobe and a select line. The control register holds the target PHY address, the PHY register number and two start bits, one for read and one for write. The data register holds the word to send, or the word returned by the PHY.

To write a PHY register, the host first loads the data register. It then writes the control register with the target fields and the write start bit set. To read a PHY register, it writes the control register with the read start bit set. The start bit reads back as 1 while the frame runs, and hardware clears it at the end. The host polls that bit. When a read has finished, the data register holds the PHY's reply.

The management clock is the system clock divided by `CLK_DIV`. It runs only while a frame is on the wire. MDIO output changes only when MDC falls, and MDIO input is sampled when MDC rises. No port carries a data stream, so every pin is a plain level or strobe and the block has no back-pressure.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset both registers read 0, `mdc` is low and `mdio_oe` is low.
- R2: When the control register is read, bits 13:9 give the PHY address and bits 8:4 give the register number. Bits 15:14 and 3:2 read 0. Bit 0 is the read-busy flag and bit 1 is the write-busy flag.
- R3: A control write accepted while idle always stores both address fields. If bit 0 is set, a read frame starts. Otherwise, if bit 1 is set, a write frame starts. If both bits are set, only a read starts and only bit 0 reads 1. If neither bit is set, no frame starts.
- R4: The active start bit reads 1 for exactly 64*CLK_DIV clock cycles after the write that started the frame, and then reads 0.
- R5: A frame is 64 MDC periods, sent MSB first: 32 ones, the start code 01, the opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register number, the turnaround, and then 16 data bits. On a write the turnaround is 10 and the data is the data register.
- R6: On a write, `mdio_oe` is high for all 64 bits. On a read it is high for bits 0 to 45 and low from the turnaround (bit 46) to the end.
- R7: On a read, `mdio_i` is sampled at the MDC rising edges of bits 48 to 63, MSB first. The 16 bits are placed in the data register when the frame ends.
- R8: MDC has a period of CLK_DIV clocks with equal high and low halves, and stays low while idle. `mdio_o` never changes while MDC is high.
- R9: A control write made while a frame is running is ignored. The fields, the busy bits and the frame on the wire are unchanged, and no further frame follows.
- R10: The data register returns the last value the host wrote to it, until a read frame completes and replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Read value of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The assertions assume that `CLK_DIV` is even and at least 2, and that reset is applied before the first strobe. They make no assumption about when the host writes, so control writes that arrive during a frame fall within what they cover. The bench's PHY model changes `mdio_i` only at a falling system-clock edge after an MDC rise, so the input is stable at every rising MDC edge. It places the reply bits only in the read data window. The host model polls the busy bits as software would, and it deliberately writes the control register in the middle of a frame to exercise the ignore rule.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;
  localparam int RX_POS    = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
  } mgmt_target_t;

  // Whole frame image, bit FRAME_LEN-1 goes out first.
  function automatic logic [FRAME_LEN-1:0] build_frame(input logic rd,
                                                       input mgmt_target_t t,
                                                       input logic [DATA_W-1:0] d);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] pay;
    op  = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    pay = rd ? {DATA_W{1'b1}} : d;
    return {{PRE_LEN{1'b1}}, 2'b01, op, t.phy, t.regn, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;

  logic mdc_q;
  logic edge_now;

  generate
    if (HALF == 1) begin : g_fast
      assign edge_now = run;
    end else begin : g_cnt
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (!run || cnt_q == CW'(HALF - 1)) cnt_q <= '0;
        else                                     cnt_q <= cnt_q + 1'b1;
      end
      assign edge_now = run && (cnt_q == CW'(HALF - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mdc_q <= 1'b0;
    else if (!run)     mdc_q <= 1'b0;
    else if (edge_now) mdc_q <= ~mdc_q;
  end

  assign mdc     = mdc_q;
  assign rise_tk = edge_now && !mdc_q;
  assign fall_tk = edge_now && mdc_q;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_rd,
  input  mgmt_target_t      tgt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              mdio_i,
  output logic              busy,
  output logic              is_rd,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [FRAME_LEN-1:0] sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q;
  logic                 rd_q;
  logic [DATA_W-1:0]    rx_q;
  logic                 last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign done     = busy_q && fall_tk && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        sh_q   <= build_frame(op_rd, tgt, wdata);
        idx_q  <= '0;
        busy_q <= 1'b1;
        rd_q   <= op_rd;
      end
    end else begin
      if (rise_tk && rd_q && idx_q >= IDX_W'(RX_POS))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_tk) begin
        if (last_bit) busy_q <= 1'b0;
        else          idx_q  <= idx_q + 1'b1;
        sh_q <= {sh_q[FRAME_LEN-2:0], 1'b1};
      end
    end
  end

  assign busy    = busy_q;
  assign is_rd   = rd_q;
  assign bit_idx = idx_q;
  assign rx_word = rx_q;
  assign mdio_o  = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && idx_q >= IDX_W'(TA_POS));
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              is_rd,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              start,
  output logic              op_rd,
  output mgmt_target_t      tgt_next,
  output mgmt_target_t      tgt,
  output logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] reg_rdata
);
  mgmt_target_t      tgt_q;
  logic [DATA_W-1:0] data_q;
  logic              ctrl_ok;

  assign ctrl_ok       = reg_wr && !reg_sel && !busy;
  assign tgt_next.phy  = reg_wdata[13:9];
  assign tgt_next.regn = reg_wdata[8:4];
  assign op_rd         = reg_wdata[0];
  assign start         = ctrl_ok && (reg_wdata[0] || reg_wdata[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tgt_q <= '0;
    else if (ctrl_ok) tgt_q <= tgt_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 data_q <= '0;
    else if (done && is_rd)     data_q <= rx_word;
    else if (reg_wr && reg_sel) data_q <= reg_wdata;
  end

  assign tgt       = tgt_q;
  assign data      = data_q;
  assign reg_rdata = reg_sel ? data_q
                             : {2'b00, tgt_q.phy, tgt_q.regn, 2'b00,
                                busy && !is_rd, busy && is_rd};
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              frm_busy, frm_rd, frm_done, frm_start, frm_op_rd;
  logic              rise_tk, fall_tk;
  logic [IDX_W-1:0]  frm_idx;
  logic [DATA_W-1:0] rx_word, data_q;
  mgmt_target_t      tgt_next, tgt_q;

  mdio_regfile regs_i (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata,
    .busy(frm_busy), .is_rd(frm_rd), .done(frm_done), .rx_word,
    .start(frm_start), .op_rd(frm_op_rd), .tgt_next, .tgt(tgt_q),
    .data(data_q), .reg_rdata
  );

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) clk_i (
    .clk, .rst_n, .run(frm_busy), .mdc, .rise_tk, .fall_tk
  );

  mdio_shifter frame_i (
    .clk, .rst_n, .start(frm_start), .op_rd(frm_op_rd), .tgt(tgt_next),
    .wdata(data_q), .rise_tk, .fall_tk, .mdio_i,
    .busy(frm_busy), .is_rd(frm_rd), .bit_idx(frm_idx), .done(frm_done),
    .rx_word, .mdio_o, .mdio_oe
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int CLK_DIV = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic       is_rd,
  input logic [5:0] bit_idx,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [9:0] fields
);
  localparam int FRAME_CYC = 64 * CLK_DIV;
  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  // R8
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R8
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mdc);

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && bit_idx >= 6'd46) |-> !mdio_oe);

  // R4
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == FRAME_CYC));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !reg_sel) |=> $stable(fields));
endmodule

bind mdio_mgmt mdio_mgmt_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(frm_busy), .is_rd(frm_rd), .bit_idx(frm_idx),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .fields(tgt_q)
);

// File: tb/mdio_mgmt_tb_top.sv
module mdio_mgmt_tb_top;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #4 clk = ~clk;

  mdio_mgmt #(.CLK_DIV(DIV)) dut_i (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
    .mdc, .mdio_o, .mdio_oe, .mdio_i
  );

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
  } frm_t;

  frm_t        exp_q[$];
  int          n_chk = 0, n_bad = 0;
  int          total_rises = 0, n_frames = 0;
  logic        rd_mode = 1'b0;
  logic [15:0] resp = '0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [15:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [15:0] ctrl_word(input logic [4:0] phy, input logic [4:0] rn, input logic [1:0] go);
    return {2'b00, phy, rn, 2'b00, go};
  endfunction

  task automatic push_exp(input logic rd, input logic [4:0] phy, input logic [4:0] rn, input logic [15:0] d);
    frm_t e;
    e.bits = rd ? {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rn, 18'h0}
                : {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rn, 2'b10, d};
    e.oe   = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    exp_q.push_back(e);
    n_frames++;
  endtask

  task automatic poll_idle(output int cycles);
    logic [15:0] v;
    cycles = 0;
    for (int i = 0; i < 100000; i++) begin
      reg_read(1'b0, v);
      if (v[1:0] == 2'b00) break;
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rn,
                           input logic [15:0] d, output int cycles);
    rd_mode = rd;
    resp = d;
    if (!rd) reg_write(1'b1, d);
    push_exp(rd, phy, rn, d);
    reg_write(1'b0, ctrl_word(phy, rn, rd ? 2'b01 : 2'b10));
    poll_idle(cycles);
  endtask

  // Monitor and PHY model: scoreboard compare per frame
  initial begin
    logic [63:0] got_b, got_oe;
    logic        prev;
    int          rcnt, gap;
    frm_t        e;
    prev = 0; rcnt = 0; gap = 0; got_b = '0; got_oe = '0;
    forever begin
      @(negedge clk);
      gap++;
      if (rst_n && mdc && !prev) begin
        got_b[63-rcnt]  = mdio_o;
        got_oe[63-rcnt] = mdio_oe;
        if (rcnt > 0) chk(gap == DIV, "R8 mdc period", 64'(gap), 64'(DIV));
        gap = 0;
        rcnt++;
        total_rises++;
        if (rcnt == 64) begin
          rcnt = 0;
          if (exp_q.size() == 0) chk(0, "R9 unexpected frame", got_b, 64'h0);
          else begin
            e = exp_q.pop_front();
            chk((got_b & e.oe) == (e.bits & e.oe), "R5 frame bits", got_b & e.oe, e.bits & e.oe);
            chk(got_oe == e.oe, "R6 output enable", got_oe, e.oe);
          end
        end
      end
      prev = mdc;
      mdio_i = (rd_mode && rcnt >= 48) ? resp[63-rcnt] : 1'b1;
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int cyc, tr;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(1'b0, v); chk(v == 16'h0, "R1 ctrl after reset", 64'(v), 64'h0);
    reg_read(1'b1, v); chk(v == 16'h0, "R1 data after reset", 64'(v), 64'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins after reset", {mdc, mdio_oe}, 64'h0);

    // R10 data register host write
    reg_write(1'b1, 16'h1234);
    reg_read(1'b1, v); chk(v == 16'h1234, "R10 data readback", 64'(v), 64'h1234);

    // Write frame, R4 duration, R2 layout
    run_frame(1'b0, 5'h11, 5'h0A, 16'hA55A, cyc);
    chk(cyc == 64*DIV, "R4 write busy cycles", 64'(cyc), 64'(64*DIV));
    reg_read(1'b0, v);
    chk(v == ctrl_word(5'h11, 5'h0A, 2'b00), "R2 ctrl fields", 64'(v), 64'(ctrl_word(5'h11, 5'h0A, 2'b00)));

    // Read frames, R7 data capture
    run_frame(1'b1, 5'h03, 5'h1F, 16'h3C96, cyc);
    chk(cyc == 64*DIV, "R4 read busy cycles", 64'(cyc), 64'(64*DIV));
    reg_read(1'b1, v); chk(v == 16'h3C96, "R7 read data", 64'(v), 64'h3C96);
    run_frame(1'b1, 5'h00, 5'h00, 16'h8001, cyc);
    reg_read(1'b1, v); chk(v == 16'h8001, "R7 read data edge bits", 64'(v), 64'h8001);

    // R3 both start bits: read wins
    rd_mode = 1'b1; resp = 16'h5AA5;
    push_exp(1'b1, 5'h15, 5'h0C, 16'h0);
    reg_write(1'b0, ctrl_word(5'h15, 5'h0C, 2'b11));
    reg_read(1'b0, v); chk(v[1:0] == 2'b01, "R3 both bits busy flags", 64'(v[1:0]), 64'h1);
    poll_idle(cyc);
    reg_read(1'b1, v); chk(v == 16'h5AA5, "R3 both bits read result", 64'(v), 64'h5AA5);

    // R3 no start bit: fields only
    tr = total_rises;
    reg_write(1'b0, ctrl_word(5'h07, 5'h19, 2'b00));
    repeat (10*DIV) @(negedge clk);
    chk(total_rises == tr, "R3 no frame without start bit", 64'(total_rises), 64'(tr));
    reg_read(1'b0, v);
    chk(v == ctrl_word(5'h07, 5'h19, 2'b00), "R3 fields stored", 64'(v), 64'(ctrl_word(5'h07, 5'h19, 2'b00)));

    // R9 control write during a frame
    rd_mode = 1'b0;
    reg_write(1'b1, 16'h0FF0);
    push_exp(1'b0, 5'h0F, 5'h02, 16'h0FF0);
    reg_write(1'b0, ctrl_word(5'h0F, 5'h02, 2'b10));
    repeat (100) @(negedge clk);
    reg_write(1'b0, ctrl_word(5'h1E, 5'h01, 2'b01));
    reg_read(1'b0, v);
    chk(v == ctrl_word(5'h0F, 5'h02, 2'b10), "R9 ctrl unchanged mid-frame", 64'(v), 64'(ctrl_word(5'h0F, 5'h02, 2'b10)));
    poll_idle(cyc);
    repeat (128*DIV) @(negedge clk);
    chk(total_rises == 64*n_frames, "R9 no extra frame", 64'(total_rises), 64'(64*n_frames));
    reg_read(1'b1, v); chk(v == 16'h0FF0, "R10 data kept after write frame", 64'(v), 64'h0FF0);
    chk(exp_q.size() == 0, "R5 all frames seen", 64'(exp_q.size()), 64'h0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule